// File: doc/BRIEF.md
# Ethernet Link/Activity LED Pattern Controller

This block drives the status LEDs of an Ethernet PHY. For each LED there are two configuration words. One selects a fixed behaviour: dark, lit, or following one of two shared blink waveforms. The other is a per-LED condition mask, used whenever the fixed behaviour is not enabled. The mask can light the LED for a matching link speed or duplex mode, blink it while traffic or collisions are seen, or keep it lit for 10 ms after a transmit or receive pulse. One shared polarity bit sets whether the LED pins are active-high or active-low. Its reset state is active-low.

Link status arrives as levels: link up, a 2-bit speed code, full duplex and collision. Transmit and receive activity arrive as single-cycle pulses. The two blink waveforms come from an external generator, and this block only exposes that generator's configuration word. Software reaches every register through a simple write/read port: writes are synchronous, and reads are combinational from the address.

Top module: `eth_led_ctrl`

## Requirements
- R1: Reset clears every register. With the default active-low polarity, every `led_out` pin is then 1 (dark), and every mapped address reads 0.
- R2: Register map for LED n (n = 0..2):
  - Pattern word at 0x8078-2n and force word at 0x8079-2n. Both store all 16 bits and read them back.
  - Word 0x8073 keeps bits 11:0, drives `blink_cfg` and reads back those bits.
  - Word 0x901A keeps only bit 6.
  - Any other address reads 0 and ignores writes.
  - A write is visible from the next clock cycle.
- R3: When force bit 15 is set, force bits 14:13 select the LED: 0 gives dark, 1 gives lit, 2 follows `blink_ch2` and 3 follows `blink_ch1`. The pattern word is then ignored.
- R4: When force bit 15 is clear, the LED follows its pattern word, whatever bits 14:13 hold.
- R5: Speed-on pattern bits light the LED steadily while `link_up` is 1 and `link_speed` matches. Bit 4 is for code 0 (10M), bit 5 for code 1 (100M), bit 6 for code 2 (1000M) and bit 15 for code 3 (2500M).
- R6: Duplex-on pattern bits light the LED while `link_up` is 1: bit 12 when `full_duplex` is 1, and bit 11 when `full_duplex` is 0.
- R7: Activity blinking:
  - Pattern bit 10 (TX) or bit 9 (RX) makes the LED follow `blink_ch1` for ACT_MS milliseconds after each pulse. This overrides the steady-on level.
  - This applies only while some enabled speed-on or duplex-on condition matches.
- R8: Pattern bit 13 (bypass) lets an enabled activity or collision blink act even when no speed or duplex condition matches.
- R9: Pattern bit 8 (TX) or bit 7 (RX) keeps the LED lit for CLK_HZ/100 cycles (10 ms) after a pulse. A new pulse restarts the count.
- R10: Bit 6 of word 0x901A set to 1 makes all pins active-high (pin = 1 when lit). When it is 0, all pins are active-low.
- R11: A pattern word of zero with force bit 15 clear keeps the LED dark, whatever the link and activity inputs do.
- R12: Speed-blink pattern bits make the LED follow `blink_ch1` while `link_up` is 1 at the matching speed: bit 0 for 10M, bit 1 for 100M, bit 2 for 1000M and bit 14 for 2500M. Bit 3 makes the LED follow `blink_ch1` while `collision` is 1, qualified like R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| link_up | input | 1 | Link established |
| link_speed | input | 2 | 0=10M, 1=100M, 2=1000M, 3=2500M |
| full_duplex | input | 1 | 1 = full duplex |
| collision | input | 1 | Collision seen (level) |
| tx_pulse | input | 1 | One-cycle transmit activity pulse |
| rx_pulse | input | 1 | One-cycle receive activity pulse |
| blink_ch1 | input | 1 | Blink waveform, channel 1 |
| blink_ch2 | input | 1 | Blink waveform, channel 2 |
| blink_cfg | output | 12 | Blink generator configuration word |
| led_out | output | 3 | LED pins, polarity per R10 |

## Verification
The pattern logic is tried with one mask bit at a time against link states that match and that miss:
- Each speed code, with link up and with link down, tells the four speed-on bits apart from one another.
- Both duplex values do the same for the two duplex bits.
- Activity pulses are applied with and without a matching qualifier, and with and without the bypass bit. This separates qualified blinking from bypassed blinking, and blinking from the steady level it overrides.
- Holding `blink_ch1` and `blink_ch2` at opposite static levels shows which channel a forced or blinking LED follows.
- A second pulse in the middle of the 10 ms hold shows that the count restarts rather than running out early.

// File: rtl/eth_led_pkg.sv
package eth_led_pkg;

  typedef enum logic [1:0] {
    SPD_10   = 2'd0,
    SPD_100  = 2'd1,
    SPD_1000 = 2'd2,
    SPD_2500 = 2'd3
  } speed_e;

  typedef enum logic [1:0] {
    FM_DARK = 2'd0,
    FM_LIT  = 2'd1,
    FM_CH2  = 2'd2,
    FM_CH1  = 2'd3
  } force_mode_e;

  localparam logic [15:0] ADDR_BLINK_CFG = 16'h8073;
  localparam logic [15:0] ADDR_POLARITY  = 16'h901A;
  localparam int          POL_BIT        = 6;
  localparam int          BLINK_CFG_W    = 12;

  // condition mask bit positions
  localparam int PB_S2500_ON  = 15;
  localparam int PB_S2500_BLK = 14;
  localparam int PB_BYPASS    = 13;
  localparam int PB_FDX_ON    = 12;
  localparam int PB_HDX_ON    = 11;
  localparam int PB_TX_BLK    = 10;
  localparam int PB_RX_BLK    = 9;
  localparam int PB_TX_HOLD   = 8;
  localparam int PB_RX_HOLD   = 7;
  localparam int PB_S1000_ON  = 6;
  localparam int PB_S100_ON   = 5;
  localparam int PB_S10_ON    = 4;
  localparam int PB_COL_BLK   = 3;
  localparam int PB_S1000_BLK = 2;
  localparam int PB_S100_BLK  = 1;
  localparam int PB_S10_BLK   = 0;

  function automatic logic [15:0] pattern_addr(input int n);
    return 16'h8078 - 16'(2 * n);
  endfunction

  function automatic logic [15:0] force_addr(input int n);
    return 16'h8079 - 16'(2 * n);
  endfunction

  // speed selector: bit k of sel is the enable for speed code k
  function automatic logic speed_hit(input logic [3:0] sel, input logic [1:0] spd);
    return sel[spd];
  endfunction

  function automatic logic hold_len_ok(input int len);
    return len >= 1;
  endfunction

endpackage

// File: rtl/led_regs.sv
module led_regs
  import eth_led_pkg::*;
#(
  parameter int N_LED = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [15:0]               addr,
  input  logic [15:0]               wdata,
  output logic [15:0]               rdata,
  output logic [N_LED-1:0][15:0]    pat_q,
  output logic [N_LED-1:0][15:0]    frc_q,
  output logic [BLINK_CFG_W-1:0]    blink_q,
  output logic                      pol_q
);

  genvar g;
  generate
    for (g = 0; g < N_LED; g++) begin : g_led
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pat_q[g] <= '0;
          frc_q[g] <= '0;
        end else if (wr) begin
          if (addr == pattern_addr(g)) pat_q[g] <= wdata;
          if (addr == force_addr(g))   frc_q[g] <= wdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blink_q <= '0;
      pol_q   <= 1'b0;
    end else if (wr) begin
      if (addr == ADDR_BLINK_CFG) blink_q <= wdata[BLINK_CFG_W-1:0];
      if (addr == ADDR_POLARITY)  pol_q   <= wdata[POL_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_LED; i++) begin
      if (addr == pattern_addr(i)) rdata = pat_q[i];
      if (addr == force_addr(i))   rdata = frc_q[i];
    end
    if (addr == ADDR_BLINK_CFG) rdata = {{(16-BLINK_CFG_W){1'b0}}, blink_q};
    if (addr == ADDR_POLARITY) begin
      rdata = '0;
      rdata[POL_BIT] = pol_q;
    end
  end

endmodule

// File: rtl/led_stretch.sv
module led_stretch
  import eth_led_pkg::*;
#(
  parameter int LEN = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);

  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN);

  logic [CW-1:0] cnt_q;

  initial begin
    if (!hold_len_ok(LEN)) $error("led_stretch: LEN must be at least 1");
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (trig)           cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);

endmodule

// File: rtl/led_lane.sv
module led_lane
  import eth_led_pkg::*;
(
  input  logic [15:0] pat,
  input  logic [2:0]  frc_ctl,    // {enable, mode[1:0]}
  input  logic        link_up,
  input  logic [1:0]  speed,
  input  logic        fdx,
  input  logic        col,
  input  logic        tx_act,
  input  logic        rx_act,
  input  logic        tx_hold,
  input  logic        rx_hold,
  input  logic        blk1,
  input  logic        blk2,
  output logic        qual,
  output logic        act_go,
  output logic        lit
);

  logic        spd_on, dup_on, spd_blk, act_req, hold_on, pat_lvl, frc_lvl;
  force_mode_e fmode;

  assign spd_on  = link_up & speed_hit({pat[PB_S2500_ON], pat[PB_S1000_ON],
                                        pat[PB_S100_ON],  pat[PB_S10_ON]}, speed);
  assign spd_blk = link_up & speed_hit({pat[PB_S2500_BLK], pat[PB_S1000_BLK],
                                        pat[PB_S100_BLK],  pat[PB_S10_BLK]}, speed);
  assign dup_on  = link_up & ((pat[PB_FDX_ON] & fdx) | (pat[PB_HDX_ON] & ~fdx));
  assign qual    = spd_on | dup_on;

  assign act_req = (pat[PB_TX_BLK] & tx_act) | (pat[PB_RX_BLK] & rx_act) |
                   (pat[PB_COL_BLK] & col);
  assign act_go  = act_req & (pat[PB_BYPASS] | qual);
  assign hold_on = (pat[PB_TX_HOLD] & tx_hold) | (pat[PB_RX_HOLD] & rx_hold);

  assign pat_lvl = (act_go | spd_blk) ? blk1 : (qual | hold_on);

  assign fmode = force_mode_e'(frc_ctl[1:0]);
  always_comb begin
    unique case (fmode)
      FM_DARK: frc_lvl = 1'b0;
      FM_LIT:  frc_lvl = 1'b1;
      FM_CH2:  frc_lvl = blk2;
      FM_CH1:  frc_lvl = blk1;
      default: frc_lvl = 1'b0;
    endcase
  end

  assign lit = frc_ctl[2] ? frc_lvl : pat_lvl;

endmodule

// File: rtl/eth_led_ctrl.sv
module eth_led_ctrl
  import eth_led_pkg::*;
#(
  parameter int N_LED  = 3,
  parameter int CLK_HZ = 50_000_000,
  parameter int ACT_MS = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [15:0] reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        link_up,
  input  logic [1:0]  link_speed,
  input  logic        full_duplex,
  input  logic        collision,
  input  logic        tx_pulse,
  input  logic        rx_pulse,
  input  logic        blink_ch1,
  input  logic        blink_ch2,
  output logic [11:0] blink_cfg,
  output logic [N_LED-1:0] led_out
);

  localparam int HOLD_CYC = CLK_HZ / 100;
  localparam int ACT_CYC  = (CLK_HZ / 1000) * ACT_MS;

  logic [N_LED-1:0][15:0] pat_q;
  logic [N_LED-1:0][15:0] frc_q;
  logic                   pol_q;
  logic [N_LED-1:0]       lit, qual, act_go;
  logic                   tx_act, rx_act, tx_hold, rx_hold;

  led_regs #(.N_LED(N_LED)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .pat_q(pat_q), .frc_q(frc_q), .blink_q(blink_cfg),
    .pol_q(pol_q)
  );

  led_stretch #(.LEN(ACT_CYC))  u_tx_act  (.clk(clk), .rst_n(rst_n), .trig(tx_pulse), .active(tx_act));
  led_stretch #(.LEN(ACT_CYC))  u_rx_act  (.clk(clk), .rst_n(rst_n), .trig(rx_pulse), .active(rx_act));
  led_stretch #(.LEN(HOLD_CYC)) u_tx_hold (.clk(clk), .rst_n(rst_n), .trig(tx_pulse), .active(tx_hold));
  led_stretch #(.LEN(HOLD_CYC)) u_rx_hold (.clk(clk), .rst_n(rst_n), .trig(rx_pulse), .active(rx_hold));

  genvar g;
  generate
    for (g = 0; g < N_LED; g++) begin : g_lane
      led_lane u_lane (
        .pat(pat_q[g]), .frc_ctl(frc_q[g][15:13]),
        .link_up(link_up), .speed(link_speed), .fdx(full_duplex), .col(collision),
        .tx_act(tx_act), .rx_act(rx_act), .tx_hold(tx_hold), .rx_hold(rx_hold),
        .blk1(blink_ch1), .blk2(blink_ch2),
        .qual(qual[g]), .act_go(act_go[g]), .lit(lit[g])
      );
      assign led_out[g] = pol_q ? lit[g] : ~lit[g];
    end
  endgenerate

endmodule

// File: rtl/eth_led_ctrl_chk.sv
module eth_led_ctrl_chk #(
  parameter int N_LED = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_wr,
  input logic [15:0]            reg_addr,
  input logic [15:0]            reg_wdata,
  input logic [N_LED-1:0]       led_out,
  input logic [N_LED-1:0][15:0] pat_q,
  input logic [N_LED-1:0][15:0] frc_q,
  input logic [N_LED-1:0]       lit,
  input logic                   tx_pulse,
  input logic                   tx_hold
);

  // R1: while reset is held every pin is dark for active-low polarity
  always @(negedge clk) begin
    if (!rst_n) a_r1_reset_dark: assert (led_out == '1);
  end

  // R2: a write to pattern word 0 is stored on the next cycle
  a_r2_pattern_store: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 16'h8078) |=> (pat_q[0] == $past(reg_wdata)));

  // R9: a transmit pulse always (re)starts the hold
  a_r9_hold_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pulse |=> tx_hold);

  genvar g;
  generate
    for (g = 0; g < N_LED; g++) begin : g_chk
      // R3: forced lit / forced dark
      a_r3_force_lit: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_q[g][15:13] == 3'b101) |-> lit[g]);
      a_r3_force_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_q[g][15:13] == 3'b100) |-> !lit[g]);
      // R11: empty mask, not forced -> dark
      a_r11_empty_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (!frc_q[g][15] && pat_q[g] == 16'h0) |-> !lit[g]);
    end
  endgenerate

endmodule

bind eth_led_ctrl eth_led_ctrl_chk #(.N_LED(N_LED)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .led_out(led_out), .pat_q(pat_q), .frc_q(frc_q),
  .lit(lit), .tx_pulse(tx_pulse), .tx_hold(tx_hold)
);

// File: tb/eth_led_ctrl_test.sv
module eth_led_ctrl_test;

  localparam int CLK_HZ = 10_000;
  localparam int HOLD   = CLK_HZ / 100;   // 100 cycles
  localparam int ACT    = 500;            // 50 ms at CLK_HZ

  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [15:0] reg_addr = 0, reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic        link_up = 0, full_duplex = 0, collision = 0;
  logic [1:0]  link_speed = 0;
  logic        tx_pulse = 0, rx_pulse = 0, blink_ch1 = 0, blink_ch2 = 0;
  logic [11:0] blink_cfg;
  logic [2:0]  led_out;

  int nchk = 0, nbad = 0;
  bit done = 0;
  bit act_high = 0;

  always #10 clk = ~clk;

  eth_led_ctrl #(.N_LED(3), .CLK_HZ(CLK_HZ), .ACT_MS(50)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_up(link_up),
    .link_speed(link_speed), .full_duplex(full_duplex), .collision(collision),
    .tx_pulse(tx_pulse), .rx_pulse(rx_pulse), .blink_ch1(blink_ch1),
    .blink_ch2(blink_ch2), .blink_cfg(blink_cfg), .led_out(led_out)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check16(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_led(input string tag, input int idx, input bit exp_lit);
    #2;
    check16(tag, {15'd0, led_out[idx]}, {15'd0, act_high ? exp_lit : !exp_lit});
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    tick(1);
    reg_wr = 0;
  endtask

  task automatic rd(input string tag, input logic [15:0] a, input logic [15:0] exp);
    reg_addr = a; #2;
    check16(tag, reg_rdata, exp);
  endtask

  task automatic pulse_tx();
    tx_pulse = 1; tick(1); tx_pulse = 0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 3; i++) begin
      wr(16'h8078 - 16'(2*i), 16'h0);
      wr(16'h8079 - 16'(2*i), 16'h0);
    end
    link_up = 0; collision = 0; blink_ch1 = 0; blink_ch2 = 0;
  endtask

  task automatic t_reset();
    #2;
    check16("R1 pins dark after reset", {13'd0, led_out}, 16'h0007);
    for (int i = 0; i < 3; i++) begin
      rd("R1 pattern reset", 16'h8078 - 16'(2*i), 16'h0);
      rd("R1 force reset",   16'h8079 - 16'(2*i), 16'h0);
    end
    rd("R1 blink reset", 16'h8073, 16'h0);
    rd("R1 polarity reset", 16'h901A, 16'h0);
  endtask

  task automatic t_regmap();
    wr(16'h8078, 16'h1234); rd("R2 pattern0 readback", 16'h8078, 16'h1234);
    wr(16'h8074, 16'hA5C3); rd("R2 pattern2 readback", 16'h8074, 16'hA5C3);
    wr(16'h8075, 16'h7FFF); rd("R2 force2 readback",   16'h8075, 16'h7FFF);
    wr(16'h8073, 16'hFFFF); rd("R2 blink readback",    16'h8073, 16'h0FFF);
    check16("R2 blink_cfg port", {4'd0, blink_cfg}, 16'h0FFF);
    wr(16'h901A, 16'hFFBF); rd("R2 polarity only bit6", 16'h901A, 16'h0000);
    wr(16'h807A, 16'hFFFF); rd("R2 unmapped reads zero", 16'h807A, 16'h0);
    rd("R2 unmapped write ignored", 16'h8078, 16'h1234);
    wr(16'h8073, 16'h0);
    clear_all();
  endtask

  task automatic t_force();
    blink_ch1 = 1; blink_ch2 = 0;
    wr(16'h8077, 16'h8000 | (16'd1 << 13)); check_led("R3 force lit", 1, 1);
    wr(16'h8077, 16'h8000);                 check_led("R3 force dark", 1, 0);
    wr(16'h8077, 16'h8000 | (16'd3 << 13)); check_led("R3 follows ch1", 1, 1);
    wr(16'h8077, 16'h8000 | (16'd2 << 13)); check_led("R3 follows ch2", 1, 0);
    blink_ch1 = 0; blink_ch2 = 1;           check_led("R3 follows ch2 high", 1, 1);
    link_up = 1; link_speed = 1; wr(16'h8076, 16'h0020);
    wr(16'h8077, 16'h8000);                 check_led("R3 force overrides pattern", 1, 0);
    clear_all();
  endtask

  task automatic t_speed();
    link_up = 1; link_speed = 1;
    wr(16'h8078, 16'h0020);                 check_led("R5 100M on", 0, 1);
    link_speed = 2;                         check_led("R5 1000M miss", 0, 0);
    wr(16'h8078, 16'h0040);                 check_led("R5 1000M on", 0, 1);
    link_speed = 0; wr(16'h8078, 16'h0010); check_led("R5 10M on", 0, 1);
    link_speed = 3; wr(16'h8078, 16'h8000); check_led("R5 2500M on", 0, 1);
    link_up = 0;                            check_led("R5 link down dark", 0, 0);
    link_up = 1; wr(16'h8079, 16'h2000);    check_led("R4 force bit clear uses pattern", 0, 1);
    wr(16'h8079, 16'h6000);                 check_led("R4 mode bits ignored", 0, 1);
    clear_all();
  endtask

  task automatic t_duplex();
    link_up = 1; link_speed = 0;
    wr(16'h8076, 16'h1000);
    full_duplex = 1;                        check_led("R6 full on", 1, 1);
    full_duplex = 0;                        check_led("R6 full miss", 1, 0);
    wr(16'h8076, 16'h0800);                 check_led("R6 half on", 1, 1);
    full_duplex = 1;                        check_led("R6 half miss", 1, 0);
    clear_all();
  endtask

  task automatic t_activity();
    link_up = 1; link_speed = 1; blink_ch1 = 0;
    wr(16'h8074, 16'h0420);                 check_led("R7 steady before pulse", 2, 1);
    pulse_tx();                             check_led("R7 blink overrides steady", 2, 0);
    blink_ch1 = 1;                          check_led("R7 follows ch1", 2, 1);
    blink_ch1 = 0; tick(ACT);               check_led("R7 back to steady", 2, 1);
    link_speed = 0; blink_ch1 = 1; pulse_tx();
    check_led("R7 no qualifier no blink", 2, 0);
    wr(16'h8074, 16'h0200); rx_pulse = 1; tick(1); rx_pulse = 0;
    check_led("R7 rx unqualified dark", 2, 0);
    tick(ACT + 2);
    clear_all();
  endtask

  task automatic t_bypass();
    blink_ch1 = 1;
    wr(16'h8078, 16'h2400); pulse_tx();     check_led("R8 bypass blinks without link", 0, 1);
    blink_ch1 = 0;                          check_led("R8 bypass follows ch1 low", 0, 0);
    tick(ACT + 2);
    clear_all();
  endtask

  task automatic t_hold();
    wr(16'h8078, 16'h0100);                 check_led("R9 dark before pulse", 0, 0);
    pulse_tx();                             check_led("R9 lit after pulse", 0, 1);
    tick(60); pulse_tx(); tick(60);         check_led("R9 restart extends", 0, 1);
    tick(45);                               check_led("R9 expired", 0, 0);
    wr(16'h8078, 16'h0080); rx_pulse = 1; tick(1); rx_pulse = 0;
    check_led("R9 rx hold lit", 0, 1);
    tick(ACT + 2);
    clear_all();
  endtask

  task automatic t_polarity();
    link_up = 1; link_speed = 2;
    wr(16'h8078, 16'h0040);
    wr(16'h901A, 16'h0040); act_high = 1;
    check16("R10 active-high pins", {13'd0, led_out}, 16'h0001);
    wr(16'h901A, 16'h0000); act_high = 0;
    check16("R10 active-low pins", {13'd0, led_out}, 16'h0006);
    clear_all();
  endtask

  task automatic t_zero();
    link_up = 1; full_duplex = 1; blink_ch1 = 1; collision = 1;
    pulse_tx(); rx_pulse = 1; tick(1); rx_pulse = 0;
    check16("R11 empty mask all dark", {13'd0, led_out}, 16'h0007);
    tick(ACT + 2);
    clear_all();
  endtask

  task automatic t_speed_blink();
    link_up = 1; link_speed = 1; blink_ch1 = 1;
    wr(16'h8078, 16'h0002);                 check_led("R12 100M blink high", 0, 1);
    blink_ch1 = 0;                          check_led("R12 100M blink low", 0, 0);
    link_speed = 3; blink_ch1 = 1;
    wr(16'h8078, 16'h4000);                 check_led("R12 2500M blink", 0, 1);
    link_speed = 1; wr(16'h8078, 16'h0028); collision = 1; blink_ch1 = 0;
    check_led("R12 collision blink low", 0, 0);
    collision = 0;                          check_led("R12 no collision steady", 0, 1);
    clear_all();
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1;
    tick(2);
    t_regmap();
    t_force();
    t_speed();
    t_duplex();
    t_activity();
    t_bypass();
    t_hold();
    t_polarity();
    t_zero();
    t_speed_blink();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nbad++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

endmodule